// File: doc/BRIEF.md
# Hot-Swap Power Sequencer

This block controls power for a plug-in card. It waits until the card is firmly seated, enables the rail gate drivers, and isolates the card's data bus until power is stable. It holds a supervisory reset for as long as any condition makes the card unsafe to run. All of its inputs come from comparators or connector pins and arrive asynchronously. Each one passes through a two-flop synchronizer first. Every delay is a cycle count computed from a clock-frequency parameter and a time in microseconds, so simulations can use short delays.

The card counts as seated only after both connector-detect inputs have stayed low together for the qualification time. Power-up starts once the card is seated and these further conditions hold: the manual reset request is released, neither supply is in undervoltage, no breaker fault is latched, and both output rails report discharged. An overcurrent on either rail trips a breaker latch that removes power. Only the manual reset request clears that latch. Holding the manual reset low long enough forces a hard power-off.

Internal states are IDLE, QUALIFY, RAMP, ON and DISCHARGE. Each time below is counted in clock edges from the edge that first samples a changed input. The two synchronizer edges come first and are included.

Top module: `hs_power_seq`

## Requirements
- R1: `rail_en` rises only after both `con_a_n` and `con_b_n` have been low without a break for QUAL cycles. That happens 2+QUAL+1 edges after both go low. A high on either input during qualification restarts the count from the moment it returns low.
- R2: If `mrst_n` stays low for MRST cycles, `rail_en` falls 2+MRST+1 edges after it went low. A shorter low pulse leaves `rail_en` high.
- R3: No power-up starts while `mrst_n` is low. After a power-off, power-up also waits until `lo_dis` and `hi_dis` are both 1. `rail_en` rises 2+3 edges after the last of them becomes 1, provided the card is still seated.
- R4: When `oc_lo` or `oc_hi` is 1, `fault` becomes 1 after 3 edges and `rail_en` falls one edge later. `fault` stays 1, and power stays off, until `mrst_n` is driven low. A low of even a few cycles clears it.
- R5: `sup_reset` is 1 whenever any of the following holds: a connector input is high, `mrst_n` is low, `uv_lo` or `uv_hi` is 1, `fault` is 1, or the delayed power-good term of R7 is active. It is 1 out of reset.
- R6: `pwr_good` equals `lo_rail_ok` delayed only by the 2-edge synchronizer, in both directions.
- R7: Once `pwr_good` has risen and every other term of R5 is clear, `sup_reset` falls 2+REL edges after `lo_rail_ok` rises. It returns to 1 2+ASR edges after `lo_rail_ok` falls. REL and ASR come from REL_US and ASR_US.
- R8: `bus_iso` is 0 only while the sequencer is ON and `sup_reset` is 0. It is 1 during qualification and ramp, during discharge, and whenever the reset is active.
- R9: `rail_en` is 1 only in RAMP and ON. It is entered only from qualification and drops once the sequence is aborted.
- R10: While `uv_lo` or `uv_hi` is 1, power-up is blocked, and a running rail is shut off 2+1 edges after the flag rises. Clearing the flag on a seated card raises `rail_en` 2+1 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| con_a_n | input | 1 | First connector-detect pin, low when seated |
| con_b_n | input | 1 | Second connector-detect pin, low when seated |
| mrst_n | input | 1 | Manual reset request, active low |
| uv_lo | input | 1 | Low-voltage supply under lockout threshold |
| uv_hi | input | 1 | High-voltage supply under lockout threshold |
| lo_rail_ok | input | 1 | Low output rail above its good threshold |
| lo_dis | input | 1 | Low output rail discharged below trip level |
| hi_dis | input | 1 | High output rail discharged below trip level |
| oc_lo | input | 1 | Overcurrent on low output rail |
| oc_hi | input | 1 | Overcurrent on high output rail |
| rail_en | output | 1 | Charge pumps on, rail gates driven |
| bus_iso | output | 1 | Data bus isolation, 1 keeps the bus disabled |
| pwr_good | output | 1 | Low rail good |
| fault | output | 1 | Breaker latch tripped |
| sup_reset | output | 1 | Supervisory reset, active high |

## Verification
The hardest state to reach is a rail that was forced off with its discharge flags still false while the manual reset is released. The card is still seated and fully qualified, so every other power-up condition already holds. The stimulus gets there in steps. It brings the card fully on, then holds `mrst_n` low past the hard-off time. Next it lowers the discharge flags, and only then releases `mrst_n`. This shows that the discharge flags alone gate the restart. A second hard case is a connector glitch placed at several offsets inside the qualification window. The bench sweeps the offset and times the rail rise from the end of the glitch.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_QUALIFY   = 3'd1,
        ST_RAMP      = 3'd2,
        ST_ON        = 3'd3,
        ST_DISCHARGE = 3'd4
    } seq_state_e;

    // Synchronized view of every asynchronous input.
    typedef struct packed {
        logic con_a_n;
        logic con_b_n;
        logic mrst_n;
        logic uv_lo;
        logic uv_hi;
        logic lo_ok;
        logic lo_dis;
        logic hi_dis;
        logic oc_lo;
        logic oc_hi;
    } raw_flags_t;

    localparam int FLAG_W = $bits(raw_flags_t);

    // Synchronizer contents after reset: card absent, supplies low, rails empty.
    localparam raw_flags_t FLAGS_SAFE = '{
        con_a_n: 1'b1, con_b_n: 1'b1, mrst_n: 1'b1,
        uv_lo: 1'b1, uv_hi: 1'b1, lo_ok: 1'b0,
        lo_dis: 1'b1, hi_dis: 1'b1, oc_lo: 1'b0, oc_hi: 1'b0
    };

    // Conditions the sequencer acts on.
    typedef struct packed {
        logic inserted;
        logic hard_off;
        logic fault;
        logic uv_any;
        logic con_any_hi;
        logic mrst_low;
        logic dis_both;
        logic pg;
    } seq_cond_t;

    function automatic int unsigned us_to_cycles(int unsigned clk_hz, int unsigned us);
        longint unsigned c;
        c = longint'(clk_hz) * longint'(us) / 64'd1_000_000;
        if (c < 64'd1) c = 64'd1;
        return c[31:0];
    endfunction

    function automatic int unsigned cnt_width(int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= RST_VAL;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_VAL;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hs_hold_timer.sv
// Saturating counter: done once level has held for LIMIT consecutive cycles.
module hs_hold_timer
    import hs_seq_pkg::*;
#(
    parameter int unsigned LIMIT = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic done
);
    localparam int CW = cnt_width(LIMIT);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !level) cnt <= '0;
        else if (cnt != LIM_V) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIM_V);

    // R1 / R2: a completed hold always follows an unbroken level
    p_done_after_level_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(level));
endmodule

// File: rtl/hs_breaker.sv
// Overcurrent breaker latch; the manual reset request is its only clear.
module hs_breaker (
    input  logic clk,
    input  logic rst,
    input  logic oc_any,
    input  logic clear_req,
    output logic fault
);
    always_ff @(posedge clk) begin
        if (rst)            fault <= 1'b0;
        else if (clear_req) fault <= 1'b0;
        else if (oc_any)    fault <= 1'b1;
    end

    p_trip_r4: assert property (@(posedge clk) disable iff (rst)
        (oc_any && !clear_req) |=> fault);
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (fault && !clear_req) |=> fault);
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        clear_req |=> !fault);
endmodule

// File: rtl/hs_pg_supervisor.sv
// Delayed power-good term of the supervisory reset (asymmetric timing).
module hs_pg_supervisor
    import hs_seq_pkg::*;
#(
    parameter int unsigned REL = 30,
    parameter int unsigned ASR = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pg,
    output logic pg_hold
);
    localparam int unsigned BIG = (REL > ASR) ? REL : ASR;
    localparam int CW = cnt_width(BIG);
    localparam logic [CW-1:0] REL_END = CW'(REL - 1);
    localparam logic [CW-1:0] ASR_END = CW'(ASR - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_hold <= 1'b1;
            cnt     <= '0;
        end else if (pg_hold) begin
            if (!pg)                 cnt <= '0;
            else if (cnt == REL_END) begin
                pg_hold <= 1'b0;
                cnt     <= '0;
            end else                 cnt <= cnt + 1'b1;
        end else begin
            if (pg)                  cnt <= '0;
            else if (cnt == ASR_END) begin
                pg_hold <= 1'b1;
                cnt     <= '0;
            end else                 cnt <= cnt + 1'b1;
        end
    end

    p_release_on_good_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(pg_hold) |-> $past(pg));
    p_assert_on_loss_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_hold) |-> !$past(pg));
endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
    import hs_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_cond_t  c,
    output seq_state_e state,
    output logic       rail_en
);
    seq_state_e nxt;
    logic       abort, may_start;

    always_comb begin
        abort     = c.con_any_hi | c.fault | c.hard_off | c.uv_any;
        may_start = c.inserted & ~c.mrst_low & ~c.fault & ~c.uv_any & c.dis_both;
        nxt       = state;
        unique case (state)
            ST_IDLE:      if (!c.con_any_hi) nxt = ST_QUALIFY;
            ST_QUALIFY:   if (c.con_any_hi)  nxt = ST_IDLE;
                          else if (may_start) nxt = ST_RAMP;
            ST_RAMP:      if (abort)         nxt = ST_DISCHARGE;
                          else if (c.pg)     nxt = ST_ON;
            ST_ON:        if (abort)         nxt = ST_DISCHARGE;
            ST_DISCHARGE: if (c.dis_both && !c.mrst_low) nxt = ST_IDLE;
            default:                         nxt = ST_DISCHARGE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign rail_en = (state == ST_RAMP) || (state == ST_ON);

    p_start_qualified_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(rail_en) |-> $past(c.inserted));
    p_hard_off_r2: assert property (@(posedge clk) disable iff (rst)
        c.hard_off |=> !rail_en);
    p_start_conditions_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rail_en) |-> $past(c.dis_both && !c.mrst_low));
    p_fault_kills_rail_r4: assert property (@(posedge clk) disable iff (rst)
        c.fault |=> !rail_en);
    p_enter_from_qualify_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(rail_en) |-> $past(state) == ST_QUALIFY);
    p_uv_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        c.uv_any |=> !rail_en);
endmodule

// File: rtl/hs_power_seq.sv
module hs_power_seq
    import hs_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned QUAL_US = 20_000,
    parameter int unsigned MRST_US = 20_000,
    parameter int unsigned REL_US  = 200_000,
    parameter int unsigned ASR_US  = 32,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic con_a_n,
    input  logic con_b_n,
    input  logic mrst_n,
    input  logic uv_lo,
    input  logic uv_hi,
    input  logic lo_rail_ok,
    input  logic lo_dis,
    input  logic hi_dis,
    input  logic oc_lo,
    input  logic oc_hi,
    output logic rail_en,
    output logic bus_iso,
    output logic pwr_good,
    output logic fault,
    output logic sup_reset
);
    localparam int unsigned QUAL_CYC = us_to_cycles(CLK_HZ, QUAL_US);
    localparam int unsigned MRST_CYC = us_to_cycles(CLK_HZ, MRST_US);
    localparam int unsigned REL_CYC  = us_to_cycles(CLK_HZ, REL_US);
    localparam int unsigned ASR_CYC  = us_to_cycles(CLK_HZ, ASR_US);

    raw_flags_t raw_in, f;
    seq_cond_t  cond;
    seq_state_e state;
    logic       inserted, hard_off, pg_hold;

    assign raw_in = '{
        con_a_n: con_a_n, con_b_n: con_b_n, mrst_n: mrst_n,
        uv_lo: uv_lo, uv_hi: uv_hi, lo_ok: lo_rail_ok,
        lo_dis: lo_dis, hi_dis: hi_dis, oc_lo: oc_lo, oc_hi: oc_hi
    };

    hs_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES), .RST_VAL(FLAGS_SAFE)) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(f)
    );

    hs_hold_timer #(.LIMIT(QUAL_CYC)) u_qual (
        .clk(clk), .rst(rst), .level(~f.con_a_n & ~f.con_b_n), .done(inserted)
    );

    hs_hold_timer #(.LIMIT(MRST_CYC)) u_mrst (
        .clk(clk), .rst(rst), .level(~f.mrst_n), .done(hard_off)
    );

    hs_breaker u_brk (
        .clk(clk), .rst(rst), .oc_any(f.oc_lo | f.oc_hi),
        .clear_req(~f.mrst_n), .fault(fault)
    );

    hs_pg_supervisor #(.REL(REL_CYC), .ASR(ASR_CYC)) u_pg (
        .clk(clk), .rst(rst), .pg(f.lo_ok), .pg_hold(pg_hold)
    );

    always_comb begin
        cond.inserted   = inserted;
        cond.hard_off   = hard_off;
        cond.fault      = fault;
        cond.uv_any     = f.uv_lo | f.uv_hi;
        cond.con_any_hi = f.con_a_n | f.con_b_n;
        cond.mrst_low   = ~f.mrst_n;
        cond.dis_both   = f.lo_dis & f.hi_dis;
        cond.pg         = f.lo_ok;
    end

    hs_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .c(cond), .state(state), .rail_en(rail_en)
    );

    assign pwr_good  = f.lo_ok;
    assign sup_reset = cond.con_any_hi | cond.mrst_low | cond.uv_any | fault | pg_hold;
    assign bus_iso   = ~((state == ST_ON) & ~sup_reset);

    p_bus_open_needs_rail_r8: assert property (@(posedge clk) disable iff (rst)
        !bus_iso |-> rail_en && !fault);
    p_fault_holds_reset_r5: assert property (@(posedge clk) disable iff (rst)
        fault |-> sup_reset && bus_iso);
endmodule

// File: tb/hs_power_seq_test.sv
module hs_power_seq_test;
    localparam int PERIOD  = 10;
    localparam int CLK_HZ  = 1_000_000;
    localparam int QUAL_US = 20;
    localparam int MRST_US = 12;
    localparam int REL_US  = 30;
    localparam int ASR_US  = 4;
    localparam int SYNC    = 2;
    localparam int Q   = CLK_HZ / 1_000_000 * QUAL_US;
    localparam int M   = CLK_HZ / 1_000_000 * MRST_US;
    localparam int RL  = CLK_HZ / 1_000_000 * REL_US;
    localparam int AS  = CLK_HZ / 1_000_000 * ASR_US;

    logic clk = 1'b0, rst = 1'b1;
    logic con_a_n = 1, con_b_n = 1, mrst_n = 1, uv_lo = 0, uv_hi = 0;
    logic lo_rail_ok = 0, lo_dis = 1, hi_dis = 1, oc_lo = 0, oc_hi = 0;
    logic rail_en, bus_iso, pwr_good, fault, sup_reset;
    int total = 0, bad = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    hs_power_seq #(.CLK_HZ(CLK_HZ), .QUAL_US(QUAL_US), .MRST_US(MRST_US),
                   .REL_US(REL_US), .ASR_US(ASR_US)) uut (
        .clk(clk), .rst(rst), .con_a_n(con_a_n), .con_b_n(con_b_n), .mrst_n(mrst_n),
        .uv_lo(uv_lo), .uv_hi(uv_hi), .lo_rail_ok(lo_rail_ok), .lo_dis(lo_dis),
        .hi_dis(hi_dis), .oc_lo(oc_lo), .oc_hi(oc_hi), .rail_en(rail_en),
        .bus_iso(bus_iso), .pwr_good(pwr_good), .fault(fault), .sup_reset(sup_reset)
    );

    function automatic logic pick(int which);
        case (which)
            0: return rail_en;
            1: return bus_iso;
            2: return pwr_good;
            3: return fault;
            default: return sup_reset;
        endcase
    endfunction

    task automatic check_eq(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_near(string req, int act, int exp);
        total++;
        if (act < exp - 1 || act > exp + 1) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d(+-1)", req, act, exp);
        end
    endtask

    // Counts rising edges until the chosen output reaches v (sampled 1 unit after each edge).
    task automatic wait_for(int which, logic v, output int n);
        n = 0;
        do begin
            @(posedge clk); #1;
            n++;
        end while (pick(which) !== v && n < 1000);
    endtask

    task automatic cycles(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic bring_up();
        int n;
        @(negedge clk);
        con_a_n = 0; con_b_n = 0;
        wait_for(0, 1'b1, n);
        @(negedge clk);
        lo_rail_ok = 1; lo_dis = 0; hi_dis = 0;
        wait_for(4, 1'b0, n);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n, n2;
        cycles(4);
        rst = 0;
        cycles(2);
        // Reset state
        check_eq("R9 reset rail_en", rail_en, 0);
        check_eq("R8 reset bus_iso", bus_iso, 1);
        check_eq("R6 reset pwr_good", pwr_good, 0);
        check_eq("R4 reset fault", fault, 0);
        check_eq("R5 reset sup_reset", sup_reset, 1);

        // R1 plain qualification
        @(negedge clk);
        con_a_n = 0; con_b_n = 0;
        wait_for(0, 1'b1, n);
        check_near("R1 qualify delay", n, SYNC + Q + 1);
        check_eq("R8 bus isolated during ramp", bus_iso, 1);
        @(negedge clk); con_a_n = 1; con_b_n = 1;
        cycles(10);
        check_eq("R9 rail off after removal", rail_en, 0);

        // R1 glitch sweep over positions inside the window
        for (int g = 0; g < 4; g++) begin
            @(negedge clk);
            con_a_n = 0; con_b_n = 0;
            cycles(Q / 2 + 3 * g);
            if (g[0]) con_a_n = 1; else con_b_n = 1;
            cycles(2);
            con_a_n = 0; con_b_n = 0;
            wait_for(0, 1'b1, n);
            check_near("R1 restart after glitch", n, SYNC + Q + 1);
            @(negedge clk); con_a_n = 1; con_b_n = 1;
            cycles(10);
        end

        // R6 / R7 / R8 timing of power-good and reset
        @(negedge clk); con_a_n = 0; con_b_n = 0;
        wait_for(0, 1'b1, n);
        @(negedge clk);
        lo_rail_ok = 1; lo_dis = 0; hi_dis = 0;
        wait_for(2, 1'b1, n);
        check_eq("R6 pwr_good rise latency", n, SYNC);
        wait_for(4, 1'b0, n2);
        check_near("R7 reset release delay", n + n2, SYNC + RL);
        check_eq("R8 bus open when on", bus_iso, 0);
        @(negedge clk); lo_rail_ok = 0;
        wait_for(2, 1'b0, n);
        check_eq("R6 pwr_good fall latency", n, SYNC);
        wait_for(4, 1'b1, n2);
        check_near("R7 reset assert delay", n + n2, SYNC + AS);
        check_eq("R8 bus isolated on reset", bus_iso, 1);
        check_eq("R9 rail stays on", rail_en, 1);
        @(negedge clk); lo_rail_ok = 1;
        wait_for(4, 1'b0, n);

        // Abort sweep: con_a, con_b, uv_lo, uv_hi, oc_lo, oc_hi
        for (int k = 0; k < 6; k++) begin
            bring_up();
            @(negedge clk);
            case (k)
                0: con_a_n = 1;
                1: con_b_n = 1;
                2: uv_lo = 1;
                3: uv_hi = 1;
                4: oc_lo = 1;
                default: oc_hi = 1;
            endcase
            wait_for(0, 1'b0, n);
            check_near((k >= 4) ? "R4 overcurrent power removal" :
                       (k >= 2) ? "R10 undervoltage shutoff" : "R9 removal shutoff",
                       n, (k >= 4) ? SYNC + 2 : SYNC + 1);
            check_eq("R5 reset on abort cause", sup_reset, 1);
            if (k >= 4) check_eq("R4 fault latched", fault, 1);
            @(negedge clk);
            con_a_n = 0; con_b_n = 0; uv_lo = 0; uv_hi = 0; oc_lo = 0; oc_hi = 0;
            lo_rail_ok = 0; lo_dis = 1; hi_dis = 1;
            if (k >= 4) begin
                cycles(3 * Q);
                check_eq("R4 fault held without manual reset", fault, 1);
                check_eq("R4 power stays off while tripped", rail_en, 0);
                mrst_n = 0;
                cycles(3);
                mrst_n = 1;
                cycles(4);
                check_eq("R4 short manual reset clears fault", fault, 0);
            end
            cycles(2 * Q);
        end

        // R2 hard reset
        bring_up();
        @(negedge clk); mrst_n = 0;
        cycles(M / 2);
        mrst_n = 1;
        cycles(M);
        check_eq("R2 short pulse keeps rail", rail_en, 1);
        wait_for(4, 1'b0, n);
        @(negedge clk); mrst_n = 0;
        wait_for(0, 1'b0, n);
        check_near("R2 hard off delay", n, SYNC + M + 1);
        check_eq("R5 reset while mrst low", sup_reset, 1);
        // R3 holdoff
        @(negedge clk); lo_rail_ok = 0; lo_dis = 1; hi_dis = 1;
        cycles(2 * Q);
        check_eq("R3 no start while mrst low", rail_en, 0);
        lo_dis = 0; hi_dis = 0;
        cycles(2);
        mrst_n = 1;
        cycles(2 * Q);
        check_eq("R3 no start before discharged", rail_en, 0);
        @(negedge clk); lo_dis = 1;
        cycles(Q);
        check_eq("R3 one rail discharged not enough", rail_en, 0);
        @(negedge clk); hi_dis = 1;
        wait_for(0, 1'b1, n);
        check_near("R3 start after discharge", n, SYNC + 3);

        // R10 undervoltage blocks qualification start
        @(negedge clk); con_a_n = 1; con_b_n = 1;
        cycles(10);
        uv_hi = 1;
        con_a_n = 0; con_b_n = 0;
        cycles(Q + 20);
        check_eq("R10 undervoltage blocks start", rail_en, 0);
        check_eq("R5 reset in undervoltage", sup_reset, 1);
        @(negedge clk); uv_hi = 0;
        wait_for(0, 1'b1, n);
        check_near("R10 start after supply recovers", n, SYNC + 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule